// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each cycle of a four-word burst in front of a synchronous memory array. A new access presents a starting address, which is captured. Each later continuation cycle steps the two low address bits through one of two orders. In the wrapping linear order the low bits count upward modulo four. In the interleaved order they are the start bits XORed with the number of steps taken so far. A static strap input picks the order.

A single advance/load input chooses between capturing a new address and stepping the current burst. An active-low clock enable freezes the whole sequencer when it is high, which lets a controller stretch a cycle. A capture cycle in which the select-valid input is low loads nothing and ends the burst that was running. Advance cycles after that leave the address where it is until the next successful load. The address bits above the two burst bits are only ever set by a load.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and one clock after it is released, `acc_addr` is 0. No burst is live after reset, so advance cycles keep `acc_addr` at 0 until the first load.
- R2: `mode_ilv` = 1 selects the interleaved order and `mode_ilv` = 0 selects the linear order. The strap is held constant between resets.
- R3: A clock with `clken_n` = 0, `adv_ld` = 0 and `sel_ok` = 1 makes `acc_addr` equal to that cycle's `ext_addr` from the next cycle on. This holds back to back as well.
- R4: A clock with `clken_n` = 1 leaves `acc_addr` unchanged, whatever `adv_ld`, `sel_ok` and `ext_addr` are.
- R5: A clock with `clken_n` = 0, `adv_ld` = 0 and `sel_ok` = 0 leaves `acc_addr` unchanged and ends the burst. Later advance cycles leave `acc_addr` unchanged until the next load.
- R6: Advance cycles (`clken_n` = 0, `adv_ld` = 1) never change `acc_addr` bits above bit 1.
- R7: In linear order, after k advances of a live burst the low two bits are (start + k) mod 4.
- R8: In interleaved order, after k advances of a live burst the low two bits are start XOR (k mod 4).
- R9: The fourth advance of a burst returns the low bits to the start value. The burst then continues around the same sequence and does not stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clken_n | input | 1 | Clock enable, active low; high freezes the sequencer |
| adv_ld | input | 1 | 0 = capture a new start address, 1 = step the burst |
| sel_ok | input | 1 | Device selected; sampled on capture cycles |
| mode_ilv | input | 1 | Order strap: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | Externally presented start address |
| acc_addr | output | ADDR_W | Address of the current access |

## Verification
The assertions assume that `mode_ilv` only changes while reset is applied. The linear step property compares each address with the previous one, so a strap change mid-burst would break it. The bench therefore sets the strap before each reset pulse and never touches it afterwards. The assertions also assume that inputs are settled at the clock edge. The bench drives every input just after the falling edge, which keeps them stable over the following rising edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int DEF_ADDR_W  = 18;
    localparam int DEF_BURST_W = 2;

    // Decoded action for one clock edge
    typedef enum logic [2:0] {
        CMD_KEEP  = 3'd0,   // clock enable inactive: freeze everything
        CMD_LOAD  = 3'd1,   // capture new start address, restart count
        CMD_ABORT = 3'd2,   // capture attempted while deselected: end burst
        CMD_STEP  = 3'd3,   // advance live burst
        CMD_IDLE  = 3'd4    // advance requested with no live burst
    } seq_cmd_e;

    function automatic seq_cmd_e decode_cmd(logic clken_n, logic adv_ld,
                                            logic sel_ok, logic live);
        if (clken_n)      return CMD_KEEP;
        else if (!adv_ld) return sel_ok ? CMD_LOAD : CMD_ABORT;
        else              return live ? CMD_STEP : CMD_IDLE;
    endfunction

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
(
    input  logic     clken_n,
    input  logic     adv_ld,
    input  logic     sel_ok,
    input  logic     live,
    output seq_cmd_e cmd
);

    always_comb begin
        cmd = decode_cmd(clken_n, adv_ld, sel_ok, live);
    end

endmodule

// File: rtl/burst_state_reg.sv
module burst_state_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int BURST_W = DEF_BURST_W
) (
    input  logic               clk,
    input  logic               rst,
    input  seq_cmd_e           cmd,
    input  logic [ADDR_W-1:0]  ext_addr,
    output logic [ADDR_W-1:0]  base_q,
    output logic [BURST_W-1:0] cnt_q,
    output logic               live_q
);

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        logic               live;
    } seq_state_t;

    seq_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (cmd)
            CMD_LOAD: begin
                nxt.base = ext_addr;
                nxt.cnt  = '0;
                nxt.live = 1'b1;
            end
            CMD_ABORT: nxt.live = 1'b0;
            CMD_STEP:  nxt.cnt  = cur.cnt + 1'b1;   // wraps naturally
            default:   nxt = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign base_q = cur.base;
    assign cnt_q  = cur.cnt;
    assign live_q = cur.live;

endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
    import burst_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int BURST_W = DEF_BURST_W
) (
    input  logic               mode_ilv,
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] cnt,
    output logic [ADDR_W-1:0]  addr
);

    logic [BURST_W-1:0] start_bits;
    logic [BURST_W-1:0] low_lin;
    logic [BURST_W-1:0] low_ilv;
    logic [BURST_W-1:0] low_sel;

    assign start_bits = base[BURST_W-1:0];
    assign low_lin    = start_bits + cnt;

    genvar b;
    generate
        for (b = 0; b < BURST_W; b++) begin : g_ilv_bit
            assign low_ilv[b] = start_bits[b] ^ cnt[b];
        end
    endgenerate

    assign low_sel = mode_ilv ? low_ilv : low_lin;

    generate
        if (ADDR_W > BURST_W) begin : g_upper
            assign addr = {base[ADDR_W-1:BURST_W], low_sel};
        end else begin : g_narrow
            assign addr = low_sel[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int BURST_W = DEF_BURST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clken_n,
    input  logic              adv_ld,
    input  logic              sel_ok,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    seq_cmd_e           cmd;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               burst_live;

    burst_cmd_dec u_dec (
        .clken_n (clken_n),
        .adv_ld  (adv_ld),
        .sel_ok  (sel_ok),
        .live    (burst_live),
        .cmd     (cmd)
    );

    burst_state_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .base_q   (base_q),
        .cnt_q    (cnt_q),
        .live_q   (burst_live)
    );

    burst_addr_form #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_form (
        .mode_ilv (mode_ilv),
        .base     (base_q),
        .cnt      (cnt_q),
        .addr     (acc_addr)
    );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clken_n,
    input logic              adv_ld,
    input logic              sel_ok,
    input logic              mode_ilv,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              burst_live
);

    // R4: frozen clock enable keeps the address
    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        clken_n |=> $stable(acc_addr));

    // R3: successful capture shows the presented address
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!clken_n && !adv_ld && sel_ok) |=> (acc_addr == $past(ext_addr)));

    // R5: capture while deselected leaves the address
    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (!clken_n && !adv_ld && !sel_ok) |=> $stable(acc_addr));

    // R5: capture while deselected ends the burst
    p_abort_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (!clken_n && !adv_ld && !sel_ok) |=> !burst_live);

    // R6: advancing never touches the upper bits
    p_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (!clken_n && adv_ld) |=> (acc_addr[ADDR_W-1:BURST_W] == $past(acc_addr[ADDR_W-1:BURST_W])));

    // R7: linear step adds one to the low bits, modulo the burst length
    p_lin_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!clken_n && adv_ld && burst_live && !mode_ilv)
        |=> (acc_addr[BURST_W-1:0] == BURST_W'($past(acc_addr[BURST_W-1:0]) + 1'b1)));

    // R5: advancing without a live burst leaves the address
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!clken_n && adv_ld && !burst_live) |=> $stable(acc_addr));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          clken_n;
    logic          adv_ld;
    logic          sel_ok;
    logic          mode_ilv;
    logic [AW-1:0] ext_addr;
    logic [AW-1:0] acc_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    int  m_base = 0;
    int  m_steps = 0;
    bit  m_live = 0;
    int  m_shown = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_W(2)) i_burst_addr_seq (
        .clk      (clk),
        .rst      (rst),
        .clken_n  (clken_n),
        .adv_ld   (adv_ld),
        .sel_ok   (sel_ok),
        .mode_ilv (mode_ilv),
        .ext_addr (ext_addr),
        .acc_addr (acc_addr)
    );

    function automatic int model_addr();
        int lo;
        int st;
        st = m_base % 4;
        if (mode_ilv) lo = st ^ (m_steps % 4);
        else          lo = (st + m_steps) % 4;
        return (m_base - st) + lo;
    endfunction

    task automatic check(input string req);
        n_tests++;
        if (int'(acc_addr) != m_shown) begin
            n_fail++;
            $display("FAIL %s: acc_addr=%h expected=%h", req, acc_addr, m_shown[AW-1:0]);
        end
    endtask

    // one clock: drive, update model at the edge, check after the falling edge
    task automatic cyc(input bit cke_n, input bit adv, input bit sel,
                       input int addr, input string req);
        clken_n  = cke_n;
        adv_ld   = adv;
        sel_ok   = sel;
        ext_addr = AW'(addr);
        @(posedge clk);
        if (!cke_n) begin
            if (!adv) begin
                if (sel) begin
                    m_base = addr; m_steps = 0; m_live = 1;
                end else begin
                    m_live = 0;
                end
            end else if (m_live) begin
                m_steps++;
            end
        end
        if (m_live || !cke_n) m_shown = m_live ? model_addr() : m_shown;
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset(input bit ilv);
        mode_ilv = ilv;
        rst      = 1'b1;
        clken_n  = 1'b0;
        adv_ld   = 1'b1;
        sel_ok   = 1'b0;
        ext_addr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_base = 0; m_steps = 0; m_live = 0; m_shown = 0;
        check("R1");
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog R1: acc_addr=%h expected=finish", acc_addr);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // linear order, R2 strap low
        do_reset(1'b0);
        cyc(0, 1, 1, 'h155, "R1");          // advance with no burst: stays 0
        cyc(0, 0, 1, 'h12345, "R3");         // start low bits 01
        cyc(0, 1, 0, 'h3FFFF, "R7");         // 2
        cyc(0, 1, 1, 0, "R7");               // 3
        cyc(0, 1, 1, 0, "R6");               // 0, upper untouched
        cyc(0, 1, 1, 0, "R9");               // back to 1
        cyc(0, 1, 1, 0, "R9");               // continues: 2
        cyc(1, 1, 1, 'h0AAAA, "R4");         // frozen advance
        cyc(1, 0, 1, 'h0AAAA, "R4");         // frozen load
        cyc(0, 1, 1, 0, "R4");               // resumes: 3
        cyc(0, 0, 0, 'h01111, "R5");         // deselected capture
        cyc(0, 1, 1, 0, "R5");               // no change
        cyc(0, 1, 1, 0, "R5");
        cyc(0, 0, 1, 'h2000E, "R3");         // new burst at low 10
        cyc(0, 0, 1, 'h2000F, "R3");         // back to back
        cyc(0, 1, 1, 0, "R7");               // wraps 3 -> 0
        cyc(0, 1, 1, 0, "R7");               // 1

        // interleaved order, R2 strap high
        do_reset(1'b1);
        cyc(0, 0, 1, 'h3FFFE, "R2");         // start low 10
        cyc(0, 1, 1, 0, "R8");               // 3
        cyc(0, 1, 1, 0, "R8");               // 0
        cyc(0, 1, 1, 0, "R8");               // 1
        cyc(0, 1, 1, 0, "R9");               // 2 again
        cyc(0, 0, 1, 'h00203, "R3");         // start low 11
        cyc(0, 1, 1, 0, "R8");               // 2
        cyc(1, 1, 1, 0, "R4");               // hold 2
        cyc(0, 1, 1, 0, "R8");               // 1
        cyc(0, 1, 1, 0, "R6");               // 0, upper kept
        cyc(0, 0, 0, 'h11111, "R5");
        cyc(0, 1, 1, 0, "R5");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule